// File: doc/BRIEF.md
# Single-precision to bfloat16 narrowing converter

This block takes 32-bit IEEE single-precision words on a valid/ready stream and returns 16-bit bfloat16 words on a second valid/ready stream. The sign and the full 8-bit exponent pass through, so the dynamic range is unchanged. The 23-bit fraction is cut to 7 bits. A per-sample mode bit selects one of two rules. The default is round-to-nearest with ties to even, which carries no systematic error. The other rule is truncation toward zero, which lets a test measure the bias between the two rules on the same data.

NaN, infinity, zero and subnormal inputs are classified before rounding, and each class follows its own rule. Two register stages sit between the streams. The first holds the classified input and the second holds the finished result. Backpressure at the output propagates back to the input without losing, duplicating or reordering samples. The block suits the write-back path of a numeric pipeline that stores values in 16-bit memory and feeds them back into further arithmetic.

Top module: `fp32_to_bf16`

## Requirements
- R1: Input bits are sign [31], exponent [30:23] and fraction [22:0]. Output bits are sign [15], exponent [14:7] and fraction [6:0]. When no rounding carry occurs, sign and exponent are copied unchanged and the output fraction holds the top 7 input fraction bits or their rounded value.
- R2: With in_mode = 0, a finite input rounds to the nearest bfloat16 value. When the discarded 16 bits are exactly half way (0x8000), the result is the neighbour whose fraction LSB is 0.
- R3: A rounding carry out of the 7-bit fraction increments the exponent. Rounding up from the largest finite magnitude (0x7F7F with a non-zero discard above half) gives infinity (0x7F80 or 0xFF80) with the input's sign.
- R4: With in_mode = 1, a non-NaN input gives exactly the input's upper 16 bits, so the magnitude is never increased.
- R5: Any NaN input (exponent all ones, fraction non-zero) gives a quiet NaN in both modes. The output keeps the sign, sets exponent all ones and sets fraction bit 6, keeps the remaining upper fraction bits, and is never turned into infinity.
- R6: Signed zeros and signed infinities pass through unchanged (0x0000, 0x8000, 0x7F80, 0xFF80).
- R7: Subnormal inputs follow the same rounding rule as normal values. A subnormal may round up to the smallest normal value 0x0080.
- R8: A sample accepted at a rising edge is presented on out_data after the next rising edge, provided out_ready is high. With out_ready held high the block accepts one sample per cycle.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold. Every accepted sample leaves exactly once, in acceptance order.
- R10: rst is synchronous and active high. After a reset edge, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample this cycle |
| in_data | input | 32 | Single-precision input word |
| in_mode | input | 1 | 0 = nearest-even, 1 = truncate toward zero |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample this cycle |
| out_data | output | 16 | bfloat16 result |

## Verification
The properties assume that a producer holds in_data and in_mode stable, with in_valid high, until in_ready accepts the sample. One property checks this input rule directly. The stimulus keeps to this rule by choosing a new sample and mode only after the previous one has been taken. It drives output readiness at random, so stalls occur often and in every pipeline state. Random words are biased toward exact ties, all-ones and all-zero exponents, and the largest finite magnitude, so the rounding corner cases appear many times in both modes.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;

  // Classification of an incoming floating-point word.
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUBN = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_NAN  = 3'd4
  } fp_class_e;

  // Rounding rule picked per sample.
  typedef enum logic {
    RM_NEAREST_EVEN = 1'b0,
    RM_TOWARD_ZERO  = 1'b1
  } round_mode_e;

endpackage

// File: rtl/bf16_pipe_reg.sv
module bf16_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  // A stage may load when it is empty or its content leaves this cycle.
  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (up_ready) begin
      vld_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) begin
      dat_q <= up_data;
    end
  end

endmodule

// File: rtl/bf16_classify.sv
module bf16_classify
  import bf16_cvt_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int IN_MAN_W = 23
) (
  input  logic [EXP_W+IN_MAN_W:0] word,
  output fp_class_e               cls
);

  logic [EXP_W-1:0]    exp_f;
  logic [IN_MAN_W-1:0] man_f;
  logic                exp_max, exp_min, man_nz;

  assign exp_f   = word[EXP_W+IN_MAN_W-1:IN_MAN_W];
  assign man_f   = word[IN_MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    if (exp_max)      cls = man_nz ? FC_NAN : FC_INF;
    else if (exp_min) cls = man_nz ? FC_SUBN : FC_ZERO;
    else              cls = FC_NORM;
  end

endmodule

// File: rtl/bf16_round.sv
module bf16_round
  import bf16_cvt_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_MAN_W = 7
) (
  input  logic [EXP_W+IN_MAN_W:0]  word,
  input  fp_class_e                cls,
  input  round_mode_e              mode,
  output logic [EXP_W+OUT_MAN_W:0] result
);

  localparam int IN_W  = 1 + EXP_W + IN_MAN_W;
  localparam int OUT_W = 1 + EXP_W + OUT_MAN_W;
  localparam int DROP  = IN_MAN_W - OUT_MAN_W;
  localparam logic [OUT_W-1:0] QUIET_BIT = OUT_W'(1) << (OUT_MAN_W - 1);

  logic [OUT_W-1:0] kept;
  logic             guard_b, sticky_b, bump;

  assign kept     = word[IN_W-1:DROP];
  assign guard_b  = word[DROP-1];
  assign sticky_b = |word[DROP-2:0];

  // Round up when above half, or exactly half with an odd kept LSB.
  always_comb begin
    bump = 1'b0;
    if (mode == RM_NEAREST_EVEN && (cls == FC_NORM || cls == FC_SUBN)) begin
      bump = guard_b && (sticky_b || kept[0]);
    end
  end

  // The carry out of the fraction flows into the exponent field; from the
  // largest finite magnitude it lands exactly on infinity.
  always_comb begin
    case (cls)
      FC_NAN:          result = kept | QUIET_BIT;
      FC_ZERO, FC_INF: result = kept;
      default:         result = kept + OUT_W'(bump);
    endcase
  end

endmodule

// File: rtl/fp32_to_bf16.sv
module fp32_to_bf16
  import bf16_cvt_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_MAN_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [EXP_W+IN_MAN_W:0]  in_data,
  input  logic                     in_mode,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [EXP_W+OUT_MAN_W:0] out_data
);

  localparam int IN_W  = 1 + EXP_W + IN_MAN_W;
  localparam int OUT_W = 1 + EXP_W + OUT_MAN_W;

  typedef struct packed {
    round_mode_e      mode;
    fp_class_e        cls;
    logic [IN_W-1:0]  word;
  } stage1_t;

  localparam int S1_W = $bits(stage1_t);

  fp_class_e        cls_in;
  stage1_t          s1_in, s1_out;
  logic [S1_W-1:0]  s1_bits;
  logic             s1_valid, s1_ready;
  logic [OUT_W-1:0] rounded;

  bf16_classify #(
    .EXP_W    (EXP_W),
    .IN_MAN_W (IN_MAN_W)
  ) u_classify (
    .word (in_data),
    .cls  (cls_in)
  );

  always_comb begin
    s1_in.mode = round_mode_e'(in_mode);
    s1_in.cls  = cls_in;
    s1_in.word = in_data;
  end

  // Stage 1: classified input.
  bf16_pipe_reg #(
    .W (S1_W)
  ) u_stage1 (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (s1_in),
    .dn_valid (s1_valid),
    .dn_ready (s1_ready),
    .dn_data  (s1_bits)
  );

  assign s1_out = stage1_t'(s1_bits);

  bf16_round #(
    .EXP_W     (EXP_W),
    .IN_MAN_W  (IN_MAN_W),
    .OUT_MAN_W (OUT_MAN_W)
  ) u_round (
    .word   (s1_out.word),
    .cls    (s1_out.cls),
    .mode   (s1_out.mode),
    .result (rounded)
  );

  // Stage 2: registered result driving the output stream.
  bf16_pipe_reg #(
    .W (OUT_W)
  ) u_stage2 (
    .clk      (clk),
    .rst      (rst),
    .up_valid (s1_valid),
    .up_ready (s1_ready),
    .up_data  (rounded),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

endmodule

// File: rtl/bf16_cvt_checker.sv
module bf16_cvt_checker #(
  parameter int EXP_W     = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_MAN_W = 7
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [EXP_W+IN_MAN_W:0]  in_data,
  input logic                     in_mode,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [EXP_W+OUT_MAN_W:0] out_data
);

  localparam int OUT_W = 1 + EXP_W + OUT_MAN_W;

  logic [EXP_W-1:0]     o_exp;
  logic [OUT_MAN_W-1:0] o_man;
  assign o_exp = out_data[OUT_W-2:OUT_MAN_W];
  assign o_man = out_data[OUT_MAN_W-1:0];

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_mode))); // R9

  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R8

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&o_exp) && (|o_man)) |-> o_man[OUT_MAN_W-1]); // R5

endmodule

bind fp32_to_bf16 bf16_cvt_checker #(
  .EXP_W     (EXP_W),
  .IN_MAN_W  (IN_MAN_W),
  .OUT_MAN_W (OUT_MAN_W)
) u_bf16_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_fp32_to_bf16.sv
module test_fp32_to_bf16;

  localparam int N_RAND = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q [0:N_RAND-1];

  always #5 clk = ~clk;

  fp32_to_bf16 i_fp32_to_bf16 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // Reference: add 0x7FFF plus the kept LSB, keep the top half.
  function automatic logic [15:0] ref_cvt(input logic [31:0] x, input logic trunc);
    logic [31:0] s;
    if (x[30:23] == 8'hFF && x[22:0] != 0) return x[31:16] | 16'h0040;
    if (trunc || x[30:23] == 8'hFF) return x[31:16];
    s = x + 32'h0000_7FFF + {31'd0, x[16]};
    return s[31:16];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One sample through an otherwise empty pipeline with out_ready high.
  task automatic run_one(input logic [31:0] w, input logic m, input logic [15:0] e,
                         input string tag, input bit lat_chk);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_mode = m; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    if (lat_chk) check(!out_valid, "R8 not early", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    #1;
    check(out_valid && out_data == e, tag, {15'd0, out_valid, out_data}, {15'd1, 1'b1, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sent, got, cyc;
    logic [31:0] w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid && in_ready, "R10 reset state", {30'd0, out_valid, in_ready}, 32'd1);

    run_one(32'h3F80_0000, 1'b0, 16'h3F80, "R1 one", 1'b1);
    run_one(32'hC020_0000, 1'b0, 16'hC020, "R1 negative", 1'b0);
    run_one(32'h3F80_8000, 1'b0, 16'h3F80, "R2 tie to even down", 1'b0);
    run_one(32'h3F81_8000, 1'b0, 16'h3F82, "R2 tie to even up", 1'b0);
    run_one(32'h3F80_8001, 1'b0, 16'h3F81, "R2 above half", 1'b0);
    run_one(32'h3F80_7FFF, 1'b0, 16'h3F80, "R2 below half", 1'b0);
    run_one(32'h3FFF_8000, 1'b0, 16'h4000, "R3 carry to exponent", 1'b0);
    run_one(32'h7F7F_FFFF, 1'b0, 16'h7F80, "R3 overflow to +inf", 1'b0);
    run_one(32'hFF7F_C000, 1'b0, 16'hFF80, "R3 overflow to -inf", 1'b0);
    run_one(32'h7F7F_FFFF, 1'b1, 16'h7F7F, "R4 truncate max", 1'b0);
    run_one(32'hBF81_FFFF, 1'b1, 16'hBF81, "R4 truncate negative", 1'b0);
    run_one(32'h7F80_0001, 1'b0, 16'h7FC0, "R5 low NaN nearest", 1'b0);
    run_one(32'hFF80_8000, 1'b1, 16'hFFC0, "R5 low NaN truncate", 1'b0);
    run_one(32'h7FA5_FFFF, 1'b0, 16'h7FE5, "R5 NaN not rounded", 1'b0);
    run_one(32'h8000_0000, 1'b0, 16'h8000, "R6 negative zero", 1'b0);
    run_one(32'h7F80_0000, 1'b0, 16'h7F80, "R6 +inf", 1'b0);
    run_one(32'hFF80_0000, 1'b1, 16'hFF80, "R6 -inf", 1'b0);
    run_one(32'h0000_8000, 1'b0, 16'h0000, "R7 subnormal tie down", 1'b0);
    run_one(32'h0001_8000, 1'b0, 16'h0002, "R7 subnormal tie up", 1'b0);
    run_one(32'h007F_FFFF, 1'b0, 16'h0080, "R7 subnormal to normal", 1'b0);

    // Full-rate streaming: R8 throughput, one accept per cycle.
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = 32'h4000_0000; in_mode = 1'b0;
    #1;
    check(in_ready, "R8 accept cycle 0", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_data = 32'h4040_0000;
    #1;
    check(in_ready, "R8 accept cycle 1", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid && out_data == 16'h4000, "R8 first of burst", {16'd0, out_data}, 32'h4000);
    @(negedge clk);
    #1;
    check(out_valid && out_data == 16'h4040, "R8 second of burst", {16'd0, out_data}, 32'h4040);
    @(negedge clk);

    // Random stream with stalls on both sides: R2 R3 R4 R5 R7 R9.
    sent = 0; got = 0; cyc = 0;
    while (got < N_RAND && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      out_ready = ($urandom % 4) != 0;
      if (!in_valid && sent < N_RAND && ($urandom % 3) != 0) begin
        w = $urandom;
        case ($urandom % 7)
          0: w[15:0] = 16'h8000;
          1: w[15:0] = 16'h7FFF;
          2: w[30:23] = 8'hFF;
          3: w[30:23] = 8'h00;
          4: w[30:16] = 15'h7F7F;
          5: w[16:0] = {1'b1, 16'h8000};
          default: ;
        endcase
        in_data = w;
        in_mode = $urandom % 2;
        in_valid = 1'b1;
      end
      #1;
      if (out_valid && out_ready) begin
        check(out_data == exp_q[got], "R9 stream order/value", {16'd0, out_data},
              {16'd0, exp_q[got]});
        got++;
      end
      if (in_valid && in_ready) begin
        exp_q[sent] = ref_cvt(in_data, in_mode);
        sent++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
      end
    end
    check(got == N_RAND, "R9 no loss", got, N_RAND);
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R9 no duplicate", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule